// File: doc/BRIEF.md
# Tone Steering Guard-Time Validator

This block replaces the resistor-capacitor steering network that sits behind a dual-tone detector. The detector drives an early-steering level, high while it sees a valid tone pair, and a 4-bit code for that pair. The validator times how long that level stays high before it accepts a digit. It latches the code into a receive register, raises a delayed-steering flag after a short settling gap, and emits a one-cycle event that the surrounding status logic uses to set its receive-full and interrupt bits. Frequency detection is not part of this block.

Both directions are guarded. A tone shorter than the tone-present guard is never registered. While a digit is held, a gap shorter than the tone-absent guard is treated as a dropout, so one long key press produces exactly one registration. Guard lengths are counted in millisecond ticks from a prescaler on the system clock, and both lengths come from configuration inputs. With both guards set to 30 ticks, a 40 ms tone is accepted and a 20 ms tone is rejected. The same setting makes a 40 ms pause a valid interdigit gap and causes a 20 ms dropout to be ignored.

Top module: `dtmf_steer_guard`

## Requirements
- R1: A code is registered only after `est_in` has stayed high, with no interruption, for `present_guard` ticks while the flag is low. With a guard of 30 ticks, a 45 ms tone registers and an 18 ms tone does not.
- R2: On registration, `rx_code` takes `code_in` at once. `dly_steer` rises exactly `SETTLE_CYC` clock cycles later.
- R3: Once `dly_steer` is high, it falls only after `est_in` has stayed low for `absent_guard` ticks. It is still high 20 ms into a pause and low 50 ms into it, with a guard of 30.
- R4: While the flag is high, a dropout shorter than the absent guard leaves `dly_steer` and `rx_code` unchanged. It causes no second registration.
- R5: `rx_code` keeps its value after the tone ends and after the flag falls, until the next registration.
- R6: Both timers restart from zero whenever `est_in` toggles before they expire. Two 20 ms high periods split by a 2 ms gap do not register. Two 20 ms low periods split by a 1 ms high do not clear the flag.
- R7: Every rising edge of `dly_steer` comes with `rx_event` high for exactly one cycle, and `rx_event` is never high at any other time.
- R8: One tick lasts `CLK_PER_TICK` clock cycles. Guard values, which must be at least 1, are read from `present_guard` and `absent_guard`. With both set to 10, a 15 ms tone registers and a 6 ms tone does not.
- R9: After reset, `dly_steer`, `rx_event` and `rx_code` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| est_in | input | 1 | Early steering from the tone detector, high while a pair is seen |
| code_in | input | 4 | Detected 4-bit digit code |
| present_guard | input | GUARD_W (8) | Tone-present guard in ticks |
| absent_guard | input | GUARD_W (8) | Tone-absent guard in ticks |
| rx_code | output | 4 | Receive register holding the last registered code |
| dly_steer | output | 1 | Delayed-steering flag |
| rx_event | output | 1 | One-cycle pulse when the flag rises |

## Verification
The checker watches four things on every cycle. It confirms that a registration only happens on a tick with early steering high, and never while the flag is held. It confirms that the flag only falls after a low early-steering level, and that `rx_event` is a single-cycle pulse tied to the flag's rising edge. It also confirms that the receive code changes only in the cycle after a registration. The bench scenarios cover the timing claims: accept and reject thresholds in milliseconds, timer restarts on toggles, the settling gap between code and flag, and dropout tolerance. These depend on pulse lengths chosen across many ticks, and only stimulus over time can show them.

// File: rtl/dtmf_guard_pkg.sv
package dtmf_guard_pkg;

  localparam int unsigned CODE_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_HELD   = 2'd2
  } steer_state_e;

  // Decide whether the tick about to be counted completes the guard window.
  function automatic logic guard_reached(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

endpackage

// File: rtl/guard_tick_gen.sv
module guard_tick_gen #(
  parameter int unsigned CLK_PER_TICK = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned TW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam logic [TW-1:0] LAST = TW'(CLK_PER_TICK - 1);

  logic [TW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      tick  <= 1'b0;
    end else if (div_q == LAST) begin
      div_q <= '0;
      tick  <= 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/guard_run_timer.sv
module guard_run_timer
  import dtmf_guard_pkg::*;
#(
  parameter int unsigned GUARD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  input  logic [GUARD_W-1:0] limit,
  output logic               expire
);
  logic [GUARD_W-1:0] cnt_q;
  logic               reach;

  always_comb begin
    reach  = guard_reached(32'(cnt_q), 32'(limit));
    expire = run && tick && reach;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (reach) cnt_q <= '0;
      else       cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import dtmf_guard_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_fire,
  input  logic              drop_fire,
  input  logic [CODE_W-1:0] code_in,
  output steer_state_e      state,
  output logic [CODE_W-1:0] rx_code,
  output logic              dly_steer,
  output logic              rx_event
);
  localparam int unsigned SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC + 1) : 1;
  localparam logic [SW-1:0] SETTLE_LOAD = SW'(SETTLE_CYC - 1);

  logic [SW-1:0] settle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      settle_q  <= '0;
      rx_code   <= '0;
      dly_steer <= 1'b0;
      rx_event  <= 1'b0;
    end else begin
      rx_event <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (reg_fire) begin
            rx_code  <= code_in;
            settle_q <= SETTLE_LOAD;
            state    <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (settle_q == '0) begin
            dly_steer <= 1'b1;
            rx_event  <= 1'b1;
            state     <= ST_HELD;
          end else begin
            settle_q <= settle_q - 1'b1;
          end
        end
        ST_HELD: begin
          if (drop_fire) begin
            dly_steer <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dtmf_steer_guard.sv
module dtmf_steer_guard
  import dtmf_guard_pkg::*;
#(
  parameter int unsigned CLK_PER_TICK = 50000,
  parameter int unsigned GUARD_W      = 8,
  parameter int unsigned SETTLE_CYC   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               est_in,
  input  logic [3:0]         code_in,
  input  logic [GUARD_W-1:0] present_guard,
  input  logic [GUARD_W-1:0] absent_guard,
  output logic [3:0]         rx_code,
  output logic               dly_steer,
  output logic               rx_event
);
  // Named internal events, visible to the bound checker
  logic         tick_w;
  logic         reg_fire;
  logic         drop_fire;
  logic         present_run;
  logic         absent_run;
  steer_state_e state_w;

  always_comb begin
    present_run = est_in && (state_w == ST_IDLE);
    absent_run  = !est_in && (state_w == ST_HELD);
  end

  guard_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) tick_i (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_w)
  );

  guard_run_timer #(.GUARD_W(GUARD_W)) present_tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (present_run),
    .tick  (tick_w),
    .limit (present_guard),
    .expire(reg_fire)
  );

  guard_run_timer #(.GUARD_W(GUARD_W)) absent_tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (absent_run),
    .tick  (tick_w),
    .limit (absent_guard),
    .expire(drop_fire)
  );

  steer_ctrl #(.SETTLE_CYC(SETTLE_CYC)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_fire (reg_fire),
    .drop_fire(drop_fire),
    .code_in  (code_in),
    .state    (state_w),
    .rx_code  (rx_code),
    .dly_steer(dly_steer),
    .rx_event (rx_event)
  );
endmodule

// File: rtl/dtmf_steer_guard_chk.sv
module dtmf_steer_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       est_in,
  input logic       tick,
  input logic       reg_fire,
  input logic       drop_fire,
  input logic       dly_steer,
  input logic       rx_event,
  input logic [3:0] rx_code
);
  AST_REG_NEEDS_EST: assert property (@(posedge clk) disable iff (!rst_n)
    reg_fire |-> (est_in && tick)); // R1

  AST_CODE_ONLY_ON_REG: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_fire |=> $stable(rx_code)); // R5

  AST_FALL_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dly_steer) |-> !$past(est_in)); // R3

  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    drop_fire |=> !dly_steer); // R3

  AST_NO_REREG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    dly_steer |-> !reg_fire); // R4

  AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_event |=> !rx_event); // R7

  AST_EVENT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_event |-> $rose(dly_steer)); // R7

  AST_RISE_HAS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dly_steer) |-> rx_event); // R7
endmodule

bind dtmf_steer_guard dtmf_steer_guard_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .est_in   (est_in),
  .tick     (tick_w),
  .reg_fire (reg_fire),
  .drop_fire(drop_fire),
  .dly_steer(dly_steer),
  .rx_event (rx_event),
  .rx_code  (rx_code)
);

// File: tb/dtmf_steer_guard_tb_top.sv
`timescale 1ns/1ps
module dtmf_steer_guard_tb_top;
  localparam int unsigned TICK_CYC = 4;
  localparam int unsigned SETTLE   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       est_in = 1'b0;
  logic [3:0] code_in = 4'h0;
  logic [7:0] present_guard = 8'd30;
  logic [7:0] absent_guard = 8'd30;
  logic [3:0] rx_code;
  logic       dly_steer;
  logic       rx_event;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int code_cyc = 0;
  logic [3:0] prev_code = 4'h0;
  logic [3:0] exp_q[$];
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dtmf_steer_guard #(.CLK_PER_TICK(TICK_CYC), .GUARD_W(8), .SETTLE_CYC(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .est_in(est_in), .code_in(code_in),
    .present_guard(present_guard), .absent_guard(absent_guard),
    .rx_code(rx_code), .dly_steer(dly_steer), .rx_event(rx_event)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ms(input int ms);
    repeat (ms * TICK_CYC) @(negedge clk);
  endtask

  // Driver: pushes the expected code before the tone starts
  task automatic tone(input logic [3:0] c, input int ms, input bit expect_reg);
    if (expect_reg) exp_q.push_back(c);
    @(negedge clk);
    code_in = c;
    est_in  = 1'b1;
    wait_ms(ms);
    est_in  = 1'b0;
  endtask

  task automatic gap(input int ms);
    est_in = 1'b0;
    wait_ms(ms);
  endtask

  // Monitor: pops expected codes on each event, checks settle gap
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rx_code != prev_code) begin
        prev_code = rx_code;
        code_cyc  = cyc;
      end
      if (rx_event) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected event", 1, 0);
        end else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          check(rx_code == e, "R1 registered code", rx_code, e);
          check(dly_steer, "R7 flag high with event", dly_steer, 1);
          check(cyc - code_cyc == SETTLE, "R2 settle gap", cyc - code_cyc, SETTLE);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check(dly_steer == 1'b0, "R9 flag reset", dly_steer, 0);
    check(rx_code == 4'h0, "R9 code reset", rx_code, 0);
    check(rx_event == 1'b0, "R9 event reset", rx_event, 0);
    rst_n = 1'b1;
    wait_ms(3);

    // Valid tone, then timed pause
    tone(4'h5, 45, 1'b1);
    check(dly_steer == 1'b1, "R1 flag after 45ms", dly_steer, 1);
    gap(20);
    check(dly_steer == 1'b1, "R3 flag held at 20ms pause", dly_steer, 1);
    gap(30);
    check(dly_steer == 1'b0, "R3 flag cleared at 50ms pause", dly_steer, 0);
    check(rx_code == 4'h5, "R5 code retained", rx_code, 5);

    // Too short
    tone(4'h9, 18, 1'b0);
    gap(50);
    check(dly_steer == 1'b0, "R1 short tone rejected", dly_steer, 0);
    check(rx_code == 4'h5, "R1 short tone code kept", rx_code, 5);

    // Present timer restart on a short gap
    tone(4'h6, 20, 1'b0);
    gap(2);
    tone(4'h6, 20, 1'b0);
    gap(50);
    check(dly_steer == 1'b0, "R6 present restart", dly_steer, 0);
    check(rx_code == 4'h5, "R6 present restart code", rx_code, 5);

    // Dropout inside a held digit
    tone(4'hC, 45, 1'b1);
    gap(15);
    check(dly_steer == 1'b1, "R4 flag through dropout", dly_steer, 1);
    tone(4'hC, 30, 1'b0);
    check(dly_steer == 1'b1, "R4 flag after resume", dly_steer, 1);
    check(rx_code == 4'hC, "R4 code after dropout", rx_code, 12);
    gap(50);
    check(dly_steer == 1'b0, "R3 flag cleared", dly_steer, 0);

    // Absent timer restart on a brief return of steering
    tone(4'h3, 45, 1'b1);
    gap(20);
    tone(4'h3, 1, 1'b0);
    gap(20);
    check(dly_steer == 1'b1, "R6 absent restart", dly_steer, 1);
    gap(30);
    check(dly_steer == 1'b0, "R6 absent expiry", dly_steer, 0);
    check(rx_code == 4'h3, "R5 code after clear", rx_code, 3);

    // Shorter configured guards
    present_guard = 8'd10;
    absent_guard  = 8'd10;
    tone(4'h7, 6, 1'b0);
    gap(20);
    check(rx_code == 4'h3, "R8 6ms rejected at guard 10", rx_code, 3);
    tone(4'hA, 15, 1'b1);
    gap(20);
    check(dly_steer == 1'b0, "R8 flag cleared at guard 10", dly_steer, 0);
    check(rx_code == 4'hA, "R8 15ms accepted at guard 10", rx_code, 10);

    wait_ms(2);
    check(exp_q.size() == 0, "R7 all expected events seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule